// File: doc/BRIEF.md
# Cascaded Audio Clock Divider

This block turns one source clock into two slower audio clocks. It builds a master clock (HCK) from three stages in series: a prescaler that divides by 1 or by 8, a programmable divider that divides by 1 to 256, and a fixed divide-by-two. It then builds a serial bit clock (SCK) by dividing HCK by a further programmable factor of 1 to 16. Each clock is delivered as a one-cycle enable pulse per period and as a level waveform, both in the source clock domain. Downstream logic either gates the source clock with the enable or drives a pad from the level.

Software writes the divisor values; the block performs no search. Each divisor field holds the ratio minus one. A new field value is held in a shadow register and is loaded only when the stage it controls reaches the end of its current period, so a change never shortens or stretches a period already in progress. Two mode inputs change the HCK source. In direct mode the source clock itself serves as HCK, so SCK comes from the final stage alone. In input mode the HCK pad is an input: its rising edges, after synchronisation, clock the SCK stage, and the internal HCK stages stop.

Top module: `acd_chain`

## Requirements
- R1: While rst_n is low, hck_en_o, hck_clk_o, sck_en_o and sck_clk_o are all 0.
- R2: In chain mode (hck_out_i=1, hck_bypass_i=0), HCK has a period of P x M x 2 source cycles. hck_en_o pulses once per period, and hck_clk_o is high for exactly half of each period.
- R3: pre_sel_i=0 gives P=1 and pre_sel_i=1 gives P=8.
- R4: pm_div_i holds M-1, so field values 0 to 255 give M = 1 to 256.
- R5: fp_div_i holds F-1, so F runs from 1 to 16. SCK has a period of F HCK periods, sck_en_o pulses once per period, and each sck_en_o pulse coincides with an hck_en_o pulse.
- R6: Within each SCK period, sck_clk_o is high for ceil(F/2) HCK periods. Even F therefore gives 50% duty, and odd F gives a high phase one HCK period longer than the low phase.
- R7: In direct mode (hck_out_i=1, hck_bypass_i=1), hck_en_o is 1 on every cycle and hck_clk_o is held high. SCK then has a period of F source cycles.
- R8: In input mode (hck_out_i=0), hck_oe_o, hck_en_o and hck_clk_o are 0. Each synchronised rising edge of ext_hck_i counts as one HCK period for the SCK stage. pre_sel_i, pm_div_i and hck_bypass_i have no effect in this mode.
- R9: A divisor field change takes effect only at the terminal count of its stage. The SCK period in progress when fp_div_i changes keeps the old length, and the following period has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel_i | input | 1 | Prescaler select: 0 divides by 1, 1 divides by 8 |
| pm_div_i | input | PM_W | Middle divider ratio minus one |
| fp_div_i | input | FP_W | Bit-clock divider ratio minus one |
| hck_bypass_i | input | 1 | Direct mode: the source clock is used as HCK |
| hck_out_i | input | 1 | HCK pad direction: 1 output, 0 input |
| ext_hck_i | input | 1 | External HCK, used in input mode |
| hck_oe_o | output | 1 | HCK pad output enable |
| hck_en_o | output | 1 | One-cycle pulse per HCK period |
| hck_clk_o | output | 1 | HCK level waveform |
| sck_en_o | output | 1 | One-cycle pulse per SCK period |
| sck_clk_o | output | 1 | SCK level waveform |

## Verification
The bench measures each SCK period, its high time, and the number of HCK pulses and HCK high cycles inside it. It does this under several settings: chain ratios with the prescaler at 1 and at 8, the smallest and largest middle divider, even and odd bit-clock factors including 1 and 16, direct mode, and an external HCK. Period and pulse count separate errors in the prescaler, the middle divider and the bit-clock divider. Odd factors show whether the duty rounds up. HCK high time shows whether the fixed halving stage is present. A bit-clock change in the middle of a period shows whether the shadow register loads at the terminal count or at once. Input mode is also run with the internal divider fields rewritten, to show that those fields are ignored.

// File: rtl/acd_pkg.sv
package acd_pkg;

   typedef enum logic [1:0] {
      MODE_CHAIN  = 2'd0,
      MODE_DIRECT = 2'd1,
      MODE_EXT    = 2'd2
   } hck_mode_e;

   // pad direction wins over the direct-pass request
   function automatic hck_mode_e pick_mode(input logic drive_out, input logic direct);
      if (!drive_out)  return MODE_EXT;
      else if (direct) return MODE_DIRECT;
      else             return MODE_CHAIN;
   endfunction

endpackage

// File: rtl/acd_divider.sv
module acd_divider #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic [W-1:0] lim_i,
   output logic         term_o,
   output logic         high_o
);

   if (W < 1 || W > 16) begin : g_bad_w
      $error("acd_divider: W out of range");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] lim_q;
   logic [W:0]   half_w;

   assign term_o = tick_i && (cnt_q == lim_q);
   // high phase lasts ceil((lim+1)/2) input ticks
   assign half_w = {1'b0, (lim_q >> 1)} + (W+1)'(1);
   assign high_o = ({1'b0, cnt_q} < half_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (term_o) begin
         cnt_q <= '0;
         lim_q <= lim_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   // R9: the shadow limit is only replaced at a terminal count
   assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !term_o |=> $stable(lim_q));

   // R4: the count never runs past the loaded limit
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_q);

endmodule

// File: rtl/acd_half.sv
module acd_half (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic tick_o,
   output logic lvl_o
);

   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tog_q <= 1'b0;
      else if (tick_i) tog_q <= ~tog_q;
   end

   assign tick_o = tick_i & tog_q;
   assign lvl_o  = ~tog_q;

   // R2: output ticks never fall on adjacent cycles
   assert_half_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/acd_edge_sync.sv
module acd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("acd_edge_sync: STAGES out of range");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], async_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

   // R8: one tick per external edge
   assert_single_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/acd_chain.sv
module acd_chain
   import acd_pkg::*;
#(
   parameter int PM_W        = 8,
   parameter int FP_W        = 4,
   parameter int PRE_FACTOR  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pre_sel_i,
   input  logic [PM_W-1:0] pm_div_i,
   input  logic [FP_W-1:0] fp_div_i,
   input  logic            hck_bypass_i,
   input  logic            hck_out_i,
   input  logic            ext_hck_i,
   output logic            hck_oe_o,
   output logic            hck_en_o,
   output logic            hck_clk_o,
   output logic            sck_en_o,
   output logic            sck_clk_o
);

   localparam int PRE_W = (PRE_FACTOR > 1) ? $clog2(PRE_FACTOR) : 1;
   localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRE_FACTOR - 1);

   if (PRE_FACTOR < 1 || PRE_FACTOR > 256) begin : g_bad_pre
      $error("acd_chain: PRE_FACTOR out of range");
   end
   if (PM_W < 1 || PM_W > 12) begin : g_bad_pm
      $error("acd_chain: PM_W out of range");
   end

   hck_mode_e mode;
   logic      chain_on;
   logic      pre_term;
   logic      pm_term;
   logic      pm_high;
   logic      half_tick;
   logic      half_lvl;
   logic      ext_rise;
   logic      feed_tick;
   logic      fp_term;
   logic      fp_high;

   assign mode     = pick_mode(hck_out_i, hck_bypass_i);
   assign chain_on = (mode == MODE_CHAIN);

   // prescaler stage: present only when it can divide
   if (PRE_FACTOR > 1) begin : g_pre
      logic pre_high;
      logic [PRE_W-1:0] pre_lim;
      assign pre_lim = pre_sel_i ? PRE_LIM : '0;
      acd_divider #(.W(PRE_W)) u_pre (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick_i (chain_on),
         .lim_i  (pre_lim),
         .term_o (pre_term),
         .high_o (pre_high)
      );
   end else begin : g_no_pre
      assign pre_term = chain_on;
   end

   acd_divider #(.W(PM_W)) u_pm (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (pre_term),
      .lim_i  (pm_div_i),
      .term_o (pm_term),
      .high_o (pm_high)
   );

   acd_half u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (pm_term),
      .tick_o (half_tick),
      .lvl_o  (half_lvl)
   );

   acd_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_hck_i),
      .rise_o  (ext_rise)
   );

   always_comb begin
      unique case (mode)
         MODE_CHAIN:  feed_tick = half_tick;
         MODE_DIRECT: feed_tick = 1'b1;
         default:     feed_tick = ext_rise;
      endcase
   end

   acd_divider #(.W(FP_W)) u_fp (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (feed_tick),
      .lim_i  (fp_div_i),
      .term_o (fp_term),
      .high_o (fp_high)
   );

   logic hck_en_q, hck_clk_q, sck_en_q, sck_clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hck_en_q  <= 1'b0;
         hck_clk_q <= 1'b0;
         sck_en_q  <= 1'b0;
         sck_clk_q <= 1'b0;
      end else begin
         hck_en_q  <= feed_tick & (mode != MODE_EXT);
         hck_clk_q <= chain_on ? half_lvl : (mode == MODE_DIRECT);
         sck_en_q  <= fp_term;
         sck_clk_q <= fp_high;
      end
   end

   assign hck_oe_o  = hck_out_i;
   assign hck_en_o  = hck_en_q;
   assign hck_clk_o = hck_clk_q;
   assign sck_en_o  = sck_en_q;
   assign sck_clk_o = sck_clk_q;

   // R7: direct mode gives an HCK tick on every cycle
   assert_direct_every_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(hck_out_i) && $past(hck_bypass_i)) |-> hck_en_o);

   // R8: an input pad leaves the HCK outputs quiet
   assert_input_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(hck_out_i)) |-> (!hck_en_o && !hck_clk_o));

   // R5: every bit-clock pulse lands on a master-clock pulse
   assert_sck_on_hck_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(hck_out_i) && sck_en_o) |-> hck_en_o);

endmodule

// File: tb/acd_chain_bench.sv
module acd_chain_bench;
   localparam int PM_W = 8;
   localparam int FP_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pre_sel = 1'b0;
   logic [PM_W-1:0] pm_div = '0;
   logic [FP_W-1:0] fp_div = '0;
   logic byp = 1'b0;
   logic outm = 1'b1;
   logic ext_hck = 1'b0;
   logic hck_oe, hck_en, hck_clk, sck_en, sck_clk;

   always #2 clk = ~clk;

   acd_chain #(.PM_W(PM_W), .FP_W(FP_W)) u_acd_chain (
      .clk(clk), .rst_n(rst_n), .pre_sel_i(pre_sel), .pm_div_i(pm_div),
      .fp_div_i(fp_div), .hck_bypass_i(byp), .hck_out_i(outm),
      .ext_hck_i(ext_hck), .hck_oe_o(hck_oe), .hck_en_o(hck_en),
      .hck_clk_o(hck_clk), .sck_en_o(sck_en), .sck_clk_o(sck_clk)
   );

   typedef struct {int per; int hi; int hn; int hh;} exp_t;
   exp_t  q[$];
   string tq[$];
   int errors = 0, checks = 0;
   bit measuring = 0, done = 0;
   int m_per = 0, m_hi = 0, m_hn = 0, m_hh = 0;
   int ecnt = 0;

   task automatic chk(string tag, string what, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // external master clock: 6 source cycles per period
   always @(negedge clk) begin
      ext_hck = (ecnt < 3);
      ecnt = (ecnt + 1) % 6;
   end

   // monitor: measures each SCK period and pops one expected item
   always @(negedge clk) begin : mon
      exp_t e;
      string t;
      if (rst_n) begin
         m_per++;
         m_hi += int'(sck_clk);
         m_hn += int'(hck_en);
         m_hh += int'(hck_clk);
         if (sck_en) begin
            if (measuring && q.size() > 0) begin
               e = q.pop_front();
               t = tq.pop_front();
               chk(t, "sck period", m_per, e.per);
               chk(t, "sck high", m_hi, e.hi);
               chk(t, "hck pulses", m_hn, e.hn);
               chk(t, "hck high", m_hh, e.hh);
            end
            measuring = (q.size() > 0);
            m_per = 0; m_hi = 0; m_hn = 0; m_hh = 0;
         end
      end
   end

   task automatic settle(int n);
      int k = 0;
      while (k < n) begin
         @(negedge clk);
         if (sck_en) k++;
      end
   endtask

   task automatic apply(bit ps, int pm, int fp, bit b, bit o);
      wait (q.size() == 0 && !measuring);
      @(negedge clk);
      pre_sel = ps; pm_div = PM_W'(pm); fp_div = FP_W'(fp); byp = b; outm = o;
      settle(3);
   endtask

   task automatic push(int per, int hi, int hn, int hh, int n, string tag);
      for (int i = 0; i < n; i++) begin
         q.push_back('{per, hi, hn, hh});
         tq.push_back(tag);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "hck_en in reset", int'(hck_en), 0);
      chk("R1", "hck_clk in reset", int'(hck_clk), 0);
      chk("R1", "sck_en in reset", int'(sck_en), 0);
      chk("R1", "sck_clk in reset", int'(sck_clk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "hck_oe when driving", int'(hck_oe), 1);

      apply(0, 0, 0, 0, 1);  push(2, 2, 1, 1, 4, "R2");          // R2 smallest chain ratio
      apply(1, 255, 0, 0, 1); push(4096, 4096, 1, 2048, 2, "R4"); // R4 R3 largest middle ratio
      apply(0, 2, 3, 0, 1);  push(24, 12, 4, 12, 4, "R5");        // R5 even factor
      wait (q.size() == 0 && !measuring);
      push(24, 12, 4, 12, 1, "R9");                               // R9 period in progress keeps old length
      push(12, 6, 2, 6, 1, "R9");
      wait (measuring);
      repeat (5) @(negedge clk);
      fp_div = FP_W'(1);
      apply(0, 1, 4, 0, 1);  push(20, 12, 5, 10, 4, "R6");        // R6 odd factor rounds high phase up
      apply(1, 1, 1, 0, 1);  push(64, 32, 2, 32, 4, "R3");        // R3 prescaler by 8
      apply(0, 0, 15, 0, 1); push(32, 16, 16, 16, 4, "R5");       // R5 largest factor
      apply(0, 0, 2, 1, 1);  push(3, 2, 3, 3, 4, "R7");           // R7 direct mode
      apply(0, 0, 0, 1, 1);  push(1, 1, 1, 1, 4, "R7");
      apply(0, 0, 2, 0, 0);  push(18, 12, 0, 0, 4, "R8");         // R8 external master clock
      chk("R8", "hck_oe when input", int'(hck_oe), 0);
      apply(1, 200, 2, 1, 0); push(18, 12, 0, 0, 4, "R8");        // R8 internal fields ignored
      wait (q.size() == 0 && !measuring);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule